// File: doc/BRIEF.md
# DDR3 ZQ Calibration Scheduler

This block decides when a DDR3 memory controller sends ZQ calibration commands and how long the command bus must then stay quiet. Leaving self refresh triggers a long calibration sequence; a fixed number of ordinary refresh commands triggers a short calibration sequence. In both cases the ranks are calibrated one at a time. Each rank gets its own command, and a wait taken from a 4-bit power-of-two code follows every command. The wait code for long calibrations is separate from the one for short calibrations.

The controller reports every refresh it sends with `refreshTick` and the end of self refresh with `selfRefExit`. It gives the ranks that are fitted in `csPresent`. For each calibration command the block raises `zqReq` for one cycle, together with the command type and the rank index. `busBusy` tells the rest of the controller that nothing else may go onto the bus. The scheduler only runs while `ddr3En` is high.

Top module: `zq_sched`

## Requirements
- R1: A pulse on `selfRefExit` starts a long sequence. The sequence issues one request per present rank, in ascending index order, with `zqIsLong` = 1 and `zqCs` holding the binary rank index.
- R2: On every 32nd `refreshTick` pulse counted since the counter was last cleared, a short sequence starts. It visits every present rank in ascending order with `zqIsLong` = 0.
- R3: A long-calibration code of 7, 8, 9 or 10 gives a wait of 2^code clocks (128, 256, 512 or 1024).
- R4: A short-calibration code of 0 to 9 gives a wait of 2^code clocks (1 to 512).
- R5: A reserved code is used as the largest legal wait for its type: 1024 for long, 512 for short. Issuing a command with a reserved code sets `codeErr`, which only reset clears.
- R6: `busBusy` is high from the cycle of a request for exactly the wait length of that request. Inside a sequence, the next request follows exactly one wait length after the previous one.
- R7: Ranks whose `csPresent` bit is 0 get no command. An all-zero mask produces no request at all.
- R8: A `selfRefExit` in the same cycle as the 32nd refresh, or during a short sequence, gives priority to the long sequence. The short work still outstanding is dropped. The long sequence starts at the lowest present rank as soon as the current wait ends.
- R9: The refresh count returns to zero when a long sequence completes.
- R10: While `ddr3En` is low, no request is issued, and pending work and the refresh count are cleared. Events arriving during that time are ignored.
- R11: After reset, `zqReq`, `busBusy` and `codeErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ddr3En | input | 1 | Enables ZQ scheduling (DDR3 devices selected) |
| refreshTick | input | 1 | One-cycle pulse for each refresh command sent |
| selfRefExit | input | 1 | One-cycle pulse when self refresh ends |
| longCode | input | 4 | Wait code for long calibration |
| shortCode | input | 4 | Wait code for short calibration |
| csPresent | input | NUM_CS | Bit i set when rank i is fitted |
| zqReq | output | 1 | One-cycle ZQ command request |
| zqIsLong | output | 1 | 1 = long calibration, 0 = short; valid with zqReq |
| zqCs | output | CS_W | Rank index of the request; valid with zqReq |
| busBusy | output | 1 | Command bus held off for the ZQ wait |
| codeErr | output | 1 | Sticky flag: a reserved wait code was used |

## Verification
Two events can land in the same cycle: the refresh that completes a count of 32, and the end of self refresh. The bench sends 31 refreshes and then drives the final refresh and the self-refresh exit on the same edge. Only the long sequence may appear, and the bus must stay silent afterwards. In the second case, self-refresh exit arrives in the middle of a short wait. The next request must then come exactly one short wait later, as a long command to the lowest rank, and no short command may follow it.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;

  localparam int LONG_CODE_MIN  = 7;
  localparam int LONG_CODE_MAX  = 10;
  localparam int SHORT_CODE_MAX = 9;

  typedef struct packed {
    logic issue;
    logic isLong;
  } zqStrobe_t;

  function automatic logic codeBad(input logic isLong, input logic [3:0] code);
    if (isLong) return (int'(code) < LONG_CODE_MIN) || (int'(code) > LONG_CODE_MAX);
    return int'(code) > SHORT_CODE_MAX;
  endfunction

  function automatic logic [3:0] waitExp(input logic isLong, input logic [3:0] code);
    if (codeBad(isLong, code)) return isLong ? 4'(LONG_CODE_MAX) : 4'(SHORT_CODE_MAX);
    return code;
  endfunction

endpackage

// File: rtl/zq_sched_ctrl.sv
module zq_sched_ctrl
  import zq_sched_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int REF_PERIOD = 32,
  parameter int CS_W       = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ddr3En,
  input  logic              refreshTick,
  input  logic              selfRefExit,
  input  logic [NUM_CS-1:0] csPresent,
  input  logic              waitDone,
  output zqStrobe_t         strobe,
  output logic [CS_W-1:0]   issueCs
);

  localparam int REF_W = $clog2(REF_PERIOD);
  localparam int NXT_W = CS_W + 1;

  logic [REF_W-1:0] refCnt;
  logic             longPend;
  logic             shortPend;
  logic             seqActive;
  logic             seqLong;
  logic [NXT_W-1:0] nextCs;

  logic            found;
  logic [CS_W-1:0] foundIdx;
  logic            refWrap;
  logic            issueNow;
  logic            seqDone;

  // lowest present rank at or above the scan position
  always_comb begin
    found    = 1'b0;
    foundIdx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (csPresent[i] && (NXT_W'(i) >= nextCs)) begin
        found    = 1'b1;
        foundIdx = CS_W'(i);
      end
    end
  end

  assign refWrap  = refreshTick && (refCnt == REF_W'(REF_PERIOD - 1));
  assign issueNow = ddr3En && seqActive && found && waitDone;
  assign seqDone  = ddr3En && seqActive && !found && waitDone;

  assign strobe.issue  = issueNow;
  assign strobe.isLong = seqLong;
  assign issueCs       = foundIdx;

  always_ff @(posedge clk) begin
    if (!rstN || !ddr3En) begin
      refCnt    <= '0;
      longPend  <= 1'b0;
      shortPend <= 1'b0;
      seqActive <= 1'b0;
      seqLong   <= 1'b0;
      nextCs    <= '0;
    end else begin
      if (refreshTick) refCnt <= refWrap ? '0 : refCnt + REF_W'(1);
      if (seqDone && seqLong) refCnt <= '0;

      if (seqActive) begin
        if (issueNow)     nextCs    <= NXT_W'(foundIdx) + NXT_W'(1);
        else if (seqDone) seqActive <= 1'b0;
      end else if (longPend) begin
        seqActive <= 1'b1;
        seqLong   <= 1'b1;
        longPend  <= 1'b0;
        nextCs    <= '0;
      end else if (shortPend) begin
        seqActive <= 1'b1;
        seqLong   <= 1'b0;
        shortPend <= 1'b0;
        nextCs    <= '0;
      end

      if (refWrap) shortPend <= 1'b1;

      // leaving self refresh outranks any short work
      if (selfRefExit) begin
        longPend  <= 1'b1;
        shortPend <= 1'b0;
        if (!(seqActive && seqLong)) seqActive <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/zq_sched_dp.sv
module zq_sched_dp
  import zq_sched_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  zqStrobe_t       strobe,
  input  logic [CS_W-1:0] issueCs,
  input  logic [3:0]      longCode,
  input  logic [3:0]      shortCode,
  output logic            waitDone,
  output logic            zqReq,
  output logic            zqIsLong,
  output logic [CS_W-1:0] zqCs,
  output logic            busBusy,
  output logic            codeErr
);

  localparam int WAIT_W = LONG_CODE_MAX + 1;

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLen;
  logic [3:0]        selCode;
  logic              selBad;

  assign selCode = strobe.isLong ? longCode : shortCode;
  assign selBad  = codeBad(strobe.isLong, selCode);
  assign waitLen = WAIT_W'(1) << waitExp(strobe.isLong, selCode);

  assign busBusy  = waitCnt != '0;
  assign waitDone = waitCnt <= WAIT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt  <= '0;
      zqReq    <= 1'b0;
      zqIsLong <= 1'b0;
      zqCs     <= '0;
      codeErr  <= 1'b0;
    end else begin
      zqReq <= strobe.issue;
      if (strobe.issue) begin
        zqIsLong <= strobe.isLong;
        zqCs     <= issueCs;
        waitCnt  <= waitLen;
        if (selBad) codeErr <= 1'b1;
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - WAIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/zq_sched.sv
module zq_sched
  import zq_sched_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int REF_PERIOD = 32,
  parameter int CS_W       = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ddr3En,
  input  logic              refreshTick,
  input  logic              selfRefExit,
  input  logic [3:0]        longCode,
  input  logic [3:0]        shortCode,
  input  logic [NUM_CS-1:0] csPresent,
  output logic              zqReq,
  output logic              zqIsLong,
  output logic [CS_W-1:0]   zqCs,
  output logic              busBusy,
  output logic              codeErr
);

  zqStrobe_t       strobe;
  logic [CS_W-1:0] issueCs;
  logic            waitDone;

  zq_sched_ctrl #(.NUM_CS(NUM_CS), .REF_PERIOD(REF_PERIOD), .CS_W(CS_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ddr3En     (ddr3En),
    .refreshTick(refreshTick),
    .selfRefExit(selfRefExit),
    .csPresent  (csPresent),
    .waitDone   (waitDone),
    .strobe     (strobe),
    .issueCs    (issueCs)
  );

  zq_sched_dp #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .issueCs  (issueCs),
    .longCode (longCode),
    .shortCode(shortCode),
    .waitDone (waitDone),
    .zqReq    (zqReq),
    .zqIsLong (zqIsLong),
    .zqCs     (zqCs),
    .busBusy  (busBusy),
    .codeErr  (codeErr)
  );

endmodule

// File: rtl/zq_sched_chk.sv
module zq_sched_chk #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              ddr3En,
  input logic [3:0]        longCode,
  input logic [3:0]        shortCode,
  input logic [NUM_CS-1:0] csPresent,
  input logic              zqReq,
  input logic              zqIsLong,
  input logic [CS_W-1:0]   zqCs,
  input logic              busBusy,
  input logic              codeErr
);

  logic [11:0] sinceReq;
  logic [11:0] lastLen;
  logic        seenReq;
  logic [11:0] curLen;

  always_comb begin
    if (zqIsLong) curLen = (longCode >= 4'd7 && longCode <= 4'd10) ? (12'd1 << longCode) : 12'd1024;
    else          curLen = (shortCode <= 4'd9) ? (12'd1 << shortCode) : 12'd512;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceReq <= '0;
      lastLen  <= '0;
      seenReq  <= 1'b0;
    end else if (zqReq) begin
      sinceReq <= 12'd1;
      lastLen  <= curLen;
      seenReq  <= 1'b1;
    end else if (sinceReq != 12'hFFF) begin
      sinceReq <= sinceReq + 12'd1;
    end
  end

  AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    zqReq && seenReq |-> sinceReq >= lastLen); // R6

  AST_REQ_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    zqReq |-> busBusy); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |=> codeErr); // R5

  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !ddr3En |=> !zqReq); // R10

  AST_REQ_PRESENT_RANK: assert property (@(posedge clk) disable iff (!rstN)
    zqReq |-> csPresent[zqCs]); // R7

endmodule

bind zq_sched zq_sched_chk #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_zq_sched_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ddr3En   (ddr3En),
  .longCode (longCode),
  .shortCode(shortCode),
  .csPresent(csPresent),
  .zqReq    (zqReq),
  .zqIsLong (zqIsLong),
  .zqCs     (zqCs),
  .busBusy  (busBusy),
  .codeErr  (codeErr)
);

// File: tb/test_zq_sched.sv
module test_zq_sched;
  localparam int NUM_CS = 4;
  localparam int CS_W   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ddr3En = 1'b0;
  logic refreshTick = 1'b0;
  logic selfRefExit = 1'b0;
  logic [3:0] longCode = 4'd7;
  logic [3:0] shortCode = 4'd0;
  logic [NUM_CS-1:0] csPresent = 4'hF;
  logic zqReq, zqIsLong, busBusy, codeErr;
  logic [CS_W-1:0] zqCs;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  zq_sched #(.NUM_CS(NUM_CS)) i_zq_sched (
    .clk(clk), .rstN(rstN), .ddr3En(ddr3En), .refreshTick(refreshTick),
    .selfRefExit(selfRefExit), .longCode(longCode), .shortCode(shortCode),
    .csPresent(csPresent), .zqReq(zqReq), .zqIsLong(zqIsLong), .zqCs(zqCs),
    .busBusy(busBusy), .codeErr(codeErr)
  );

  function automatic int longLen(input logic [3:0] c);
    return (c >= 4'd7 && c <= 4'd10) ? (1 << c) : 1024;
  endfunction

  function automatic int shortLen(input logic [3:0] c);
    return (c <= 4'd9) ? (1 << c) : 512;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRefresh(input int n, input bit randGap);
    for (int k = 0; k < n; k++) begin
      refreshTick = 1'b1;
      step(1);
      refreshTick = 1'b0;
      if (randGap) step($urandom_range(0, 2));
    end
  endtask

  task automatic pulseExit();
    selfRefExit = 1'b1;
    step(1);
    selfRefExit = 1'b0;
  endtask

  task automatic expectQuiet(input string req, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      step(1);
      if (zqReq) seen++;
    end
    chk(req, seen, 0, "requests in quiet window");
  endtask

  task automatic waitFirst(output bit got);
    got = 0;
    for (int k = 0; k < 60; k++) begin
      if (zqReq === 1'b1) begin got = 1; return; end
      step(1);
    end
  endtask

  // expects one request per present rank, spaced n cycles, then n busy cycles
  task automatic checkSeq(input string req, input bit isLong, input logic [3:0] mask, input int n);
    bit got;
    bit first = 1;
    int k;
    for (int i = 0; i < NUM_CS; i++) begin
      if (mask[i]) begin
        if (first) begin
          waitFirst(got);
          chk(req, int'(got), 1, "first request seen");
          if (!got) return;
          first = 0;
        end else begin
          k = 0;
          do begin step(1); k++; end while (zqReq !== 1'b1 && k < n + 8);
          chk(req, k, n, "request spacing");
        end
        chk(req, int'(zqCs), i, "rank index");
        chk(req, int'(zqIsLong), int'(isLong), "command type");
      end
    end
    k = 0;
    while (busBusy === 1'b1 && k < n + 8) begin k++; step(1); end
    chk(req, k, n, "busy length");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    int k;
    void'($urandom(32'd2718));
    step(3);
    chk("R11", int'(zqReq), 0, "reset zqReq");
    chk("R11", int'(busBusy), 0, "reset busBusy");
    chk("R11", int'(codeErr), 0, "reset codeErr");
    rstN = 1'b1;
    ddr3En = 1'b1;
    step(2);

    // R1 R3: long sequence on all ranks
    longCode = 4'd7; csPresent = 4'hF;
    pulseExit();
    checkSeq("R1_R3", 1'b1, 4'hF, 128);

    // R2 R4: 31 refreshes stay quiet, the 32nd starts a short sequence
    shortCode = 4'd0;
    pulseRefresh(31, 1'b1);
    expectQuiet("R2", 20);
    pulseRefresh(1, 1'b0);
    checkSeq("R2_R4", 1'b0, 4'hF, 1);

    // R7: absent ranks skipped
    csPresent = 4'b0101; shortCode = 4'd9;
    pulseRefresh(32, 1'b1);
    checkSeq("R7_R4", 1'b0, 4'b0101, 512);

    // R9: refresh count cleared by a completed long sequence
    csPresent = 4'b0001; longCode = 4'd7; shortCode = 4'd2;
    pulseRefresh(20, 1'b1);
    pulseExit();
    checkSeq("R9", 1'b1, 4'b0001, 128);
    pulseRefresh(31, 1'b1);
    expectQuiet("R9", 20);
    pulseRefresh(1, 1'b0);
    checkSeq("R9", 1'b0, 4'b0001, 4);

    // R8: 32nd refresh and self-refresh exit in the same cycle
    csPresent = 4'b0110; longCode = 4'd8;
    pulseRefresh(31, 1'b1);
    refreshTick = 1'b1; selfRefExit = 1'b1;
    step(1);
    refreshTick = 1'b0; selfRefExit = 1'b0;
    checkSeq("R8", 1'b1, 4'b0110, 256);
    expectQuiet("R8", 300);

    // R8: self-refresh exit during a short wait
    csPresent = 4'b0011; shortCode = 4'd4; longCode = 4'd7;
    pulseRefresh(32, 1'b1);
    waitFirst(got);
    chk("R8", int'(got), 1, "short request seen");
    chk("R8", int'(zqIsLong), 0, "first is short");
    step(2);
    pulseExit();
    k = 3;
    while (zqReq !== 1'b1 && k < 40) begin step(1); k++; end
    chk("R8", k, 16, "long follows short wait");
    chk("R8", int'(zqIsLong), 1, "preempting type");
    chk("R8", int'(zqCs), 0, "preempting rank");
    k = 0;
    do begin step(1); k++; end while (zqReq !== 1'b1 && k < 140);
    chk("R8", k, 128, "second long spacing");
    chk("R8", int'(zqCs), 1, "second long rank");
    chk("R8", int'(zqIsLong), 1, "second long type");
    step(130);
    expectQuiet("R8", 300);

    // R7: empty mask gives nothing
    csPresent = 4'b0000;
    pulseExit();
    expectQuiet("R7", 100);

    // R10: disabled block ignores events and clears the count
    csPresent = 4'b1000; shortCode = 4'd3;
    pulseRefresh(20, 1'b1);
    ddr3En = 1'b0;
    step(1);
    pulseExit();
    pulseRefresh(32, 1'b0);
    expectQuiet("R10", 30);
    ddr3En = 1'b1;
    expectQuiet("R10", 30);
    pulseRefresh(31, 1'b1);
    expectQuiet("R10", 20);
    pulseRefresh(1, 1'b0);
    checkSeq("R10", 1'b0, 4'b1000, 8);

    // random legal codes and masks
    for (int it = 0; it < 8; it++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      csPresent = m;
      if (it % 2 == 0) begin
        longCode = 4'($urandom_range(7, 10));
        pulseExit();
        checkSeq("R1_R3_R6", 1'b1, m, longLen(longCode));
      end else begin
        shortCode = 4'($urandom_range(0, 9));
        pulseRefresh(32, 1'b1);
        checkSeq("R2_R4_R6", 1'b0, m, shortLen(shortCode));
      end
    end
    chk("R5", int'(codeErr), 0, "no error with legal codes");

    // R5: reserved codes
    csPresent = 4'b0001; longCode = 4'd3;
    pulseExit();
    checkSeq("R5", 1'b1, 4'b0001, longLen(4'd3));
    chk("R5", int'(codeErr), 1, "long reserved flagged");
    longCode = 4'd7; shortCode = 4'd12;
    pulseRefresh(32, 1'b1);
    checkSeq("R5", 1'b0, 4'b0001, shortLen(4'd12));
    shortCode = 4'd1;
    pulseRefresh(32, 1'b1);
    checkSeq("R5", 1'b0, 4'b0001, 2);
    chk("R5", int'(codeErr), 1, "error stays set");

    rstN = 1'b0;
    step(2);
    chk("R5_R11", int'(codeErr), 0, "reset clears error");
    chk("R11", int'(busBusy), 0, "reset busBusy");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule